// File: doc/BRIEF.md
# Channel-Mode Sample Acquisition Front End

This block sits between a 16-channel logic input bus and a sample buffer. It turns a stream of sample-enable ticks into fixed-width data words, each marked by a one-cycle valid strobe. A two-bit mode input sets what is captured. Wide mode takes all channels on every wide tick. The two narrow modes take a single byte lane, either the low lane or the high lane, on a tick that runs at twice the wide rate. Two successive lane bytes are packed into one word. Slow continuous mode takes all channels on a tick that an internal divider derives from a base tick.

The tick sources, the clocks that drive them, the storage behind the block and the input thresholds all belong to the surrounding system. The divider ratio comes in as a plain register value.

Top module: `acq_front`

## Requirements
- R1: While reset is asserted and after its release, `valid_o` is 0 and `data_o` is all zeros until the first word is emitted.
- R2: In mode 2'b00 (wide), a cycle with `tick_full_i` high captures all of `din_i`. In the next cycle `valid_o` is 1 and `data_o` holds that value.
- R3: In mode 2'b01 (narrow low lane), each `tick_half_i` captures `din_i[7:0]`. The first byte of a pair lands in `data_o[7:0]` and the second in `data_o[15:8]`. `valid_o` pulses only in the cycle after the second byte.
- R4: In mode 2'b10 (narrow high lane), the packing is the same as in R3, using `din_i[15:8]` as the captured byte.
- R5: In mode 2'b11 (slow continuous), every `div_i`-th `tick_base_i` captures all of `din_i`, and a `div_i` of 0 acts as 1. The count restarts when the mode is entered, and a base tick in the cycle the mode changes is not counted.
- R6: A change of the mode input clears the packing phase, so a pending half word is dropped and never emitted. A narrow tick in the cycle of the change is taken as the first byte of a new pair.
- R7: `data_o` changes only in a cycle in which `valid_o` is 1, and it holds its value between words.
- R8: Ticks that do not belong to the active mode are ignored. `tick_half_i` and `tick_base_i` have no effect in wide mode, `tick_full_i` has none in the narrow modes, and `tick_full_i` and `tick_half_i` have none in slow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Mode: 00 wide, 01 low lane, 10 high lane, 11 slow |
| tick_full_i | input | 1 | Sample enable for wide mode |
| tick_half_i | input | 1 | Sample enable for narrow modes (double rate) |
| tick_base_i | input | 1 | Base tick fed to the slow-mode divider |
| div_i | input | 16 | Slow-mode divide ratio (0 acts as 1) |
| din_i | input | 16 | Logic channel inputs |
| data_o | output | 16 | Captured or packed sample word |
| valid_o | output | 1 | One-cycle strobe for a new word |

## Verification
The bench builds the block with its default parameters: 16 channels, two 8-bit lanes and a 16-bit divider. This keeps byte placement directly visible in hex. The divider is run at ratios 3 and 0 so that both the counted case and the every-tick case are reached in a few cycles. A lane switch in the middle of a pair is driven to show that the stranded byte is dropped and that the tick in the switching cycle starts a new pair.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE = 2'b00,
        MODE_LOW  = 2'b01,
        MODE_HIGH = 2'b10,
        MODE_SLOW = 2'b11
    } acq_mode_e;

endpackage

// File: rtl/acq_slow_div.sv
module acq_slow_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             restart_i,
    input  logic             tick_base_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        st_d   = st_q;
        tick_o = 1'b0;
        limit  = (div_i == '0) ? '0 : div_i - 1'b1;
        if (!en_i || restart_i) begin
            st_d.cnt = '0;
        end else if (tick_base_i) begin
            if (st_q.cnt >= limit) begin
                tick_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a slow tick only appears on a counted base tick in slow mode
    a_r5_fire_on_base: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (tick_base_i && en_i && !restart_i));

    // R5: counter restarts after firing
    a_r5_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/acq_lane_pack.sv
module acq_lane_pack #(
    parameter int CH_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            upper_i,
    input  logic            restart_i,
    input  logic            tick_i,
    input  logic [CH_W-1:0] din_i,
    output logic            emit_o,
    output logic [CH_W-1:0] word_o
);

    localparam int LANE_W = CH_W / 2;

    typedef struct packed {
        logic              phase;
        logic [LANE_W-1:0] first;
    } pack_st_t;

    pack_st_t st_d, st_q;
    logic [LANE_W-1:0] lane_byte;

    always_comb begin
        lane_byte = upper_i ? din_i[CH_W-1:LANE_W] : din_i[LANE_W-1:0];
        st_d      = st_q;
        emit_o    = 1'b0;
        word_o    = {lane_byte, st_q.first};
        if (!en_i) begin
            st_d.phase = 1'b0;
        end else if (restart_i) begin
            st_d.phase = tick_i;
            if (tick_i) st_d.first = lane_byte;
        end else if (tick_i) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
                st_d.first = lane_byte;
            end else begin
                st_d.phase = 1'b0;
                emit_o     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a restart never completes a word
    a_r6_no_half_word: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |-> !emit_o);

    // R3: a word completes only on the second tick of a pair
    a_r3_pair_emit: assert property (@(posedge clk) disable iff (!rst_n)
        emit_o |=> (st_q.phase == 1'b0));

endmodule

// File: rtl/acq_front.sv
module acq_front #(
    parameter int CH_W  = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             tick_full_i,
    input  logic             tick_half_i,
    input  logic             tick_base_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [CH_W-1:0]  din_i,
    output logic [CH_W-1:0]  data_o,
    output logic             valid_o
);
    import acq_pkg::*;

    typedef struct packed {
        logic [1:0]      mode;
        logic [CH_W-1:0] data;
        logic            valid;
    } front_st_t;

    front_st_t st_d, st_q;
    acq_mode_e mode_sel;
    logic      restart;
    logic      narrow_en;
    logic      slow_en;
    logic      pk_emit;
    logic [CH_W-1:0] pk_word;
    logic      slow_tick;

    assign mode_sel  = acq_mode_e'(mode_i);
    assign restart   = (mode_i != st_q.mode);
    assign narrow_en = (mode_sel == MODE_LOW) || (mode_sel == MODE_HIGH);
    assign slow_en   = (mode_sel == MODE_SLOW);

    acq_lane_pack #(.CH_W(CH_W)) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (narrow_en),
        .upper_i   (mode_sel == MODE_HIGH),
        .restart_i (restart),
        .tick_i    (tick_half_i),
        .din_i     (din_i),
        .emit_o    (pk_emit),
        .word_o    (pk_word)
    );

    acq_slow_div #(.DIV_W(DIV_W)) i_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (slow_en),
        .restart_i   (restart),
        .tick_base_i (tick_base_i),
        .div_i       (div_i),
        .tick_o      (slow_tick)
    );

    always_comb begin
        st_d       = st_q;
        st_d.mode  = mode_i;
        st_d.valid = 1'b0;
        unique case (mode_sel)
            MODE_WIDE: if (tick_full_i) begin
                st_d.valid = 1'b1;
                st_d.data  = din_i;
            end
            MODE_LOW, MODE_HIGH: if (pk_emit) begin
                st_d.valid = 1'b1;
                st_d.data  = pk_word;
            end
            MODE_SLOW: if (slow_tick) begin
                st_d.valid = 1'b1;
                st_d.data  = din_i;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;

    // R2: wide tick yields the sampled bus next cycle
    a_r2_wide_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && tick_full_i) |=> (valid_o && data_o == $past(din_i)));

    // R7: data only moves together with valid
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o));

    // R8: without its own tick, wide mode emits nothing
    a_r8_wide_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00 && !tick_full_i) |=> !valid_o);

    // R8: without a half tick, narrow modes emit nothing
    a_r8_narrow_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 2'b01 || mode_i == 2'b10) && !tick_half_i) |=> !valid_o);

    // R5: slow mode emits only after a base tick
    a_r5_slow_base: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && !tick_base_i) |=> !valid_o);

endmodule

// File: tb/test_acq_front.sv
module test_acq_front;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic        tick_full_i = 1'b0;
    logic        tick_half_i = 1'b0;
    logic        tick_base_i = 1'b0;
    logic [15:0] div_i = 16'd1;
    logic [15:0] din_i = 16'h0000;
    logic [15:0] data_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    acq_front i_acq_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .tick_full_i (tick_full_i),
        .tick_half_i (tick_half_i),
        .tick_base_i (tick_base_i),
        .div_i       (div_i),
        .din_i       (din_i),
        .data_o      (data_o),
        .valid_o     (valid_o)
    );

    task automatic check(string req, logic exp_v, logic [15:0] exp_d);
        n_chk++;
        if (valid_o !== exp_v || data_o !== exp_d) begin
            n_bad++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     req, valid_o, data_o, exp_v, exp_d);
        end
    endtask

    // drive for one cycle from a negedge; returns at the next negedge
    task automatic drive(logic tf, logic th, logic tb, logic [15:0] d);
        tick_full_i = tf;
        tick_half_i = th;
        tick_base_i = tb;
        din_i       = d;
        @(negedge clk);
        tick_full_i = 1'b0;
        tick_half_i = 1'b0;
        tick_base_i = 1'b0;
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_i = m;
        drive(1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    task automatic t_reset();
        check("R1", 1'b0, 16'h0000);
        drive(1'b0, 1'b0, 1'b0, 16'hFFFF);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 16'hFFFF);
        check("R1", 1'b0, 16'h0000);
    endtask

    task automatic t_wide();
        drive(1'b1, 1'b0, 1'b0, 16'hA55A);
        check("R2", 1'b1, 16'hA55A);
        drive(1'b0, 1'b0, 1'b0, 16'h0F0F);
        check("R7", 1'b0, 16'hA55A);
        drive(1'b1, 1'b0, 1'b0, 16'h1234);
        check("R2", 1'b1, 16'h1234);
        drive(1'b0, 1'b1, 1'b1, 16'hFFFF);
        check("R8", 1'b0, 16'h1234);
    endtask

    task automatic t_low();
        set_mode(2'b01);
        drive(1'b0, 1'b1, 1'b0, 16'hEE11);
        check("R3", 1'b0, 16'h1234);
        drive(1'b0, 1'b1, 1'b0, 16'hDD22);
        check("R3", 1'b1, 16'h2211);
        drive(1'b1, 1'b0, 1'b0, 16'hCCCC);
        check("R8", 1'b0, 16'h2211);
    endtask

    task automatic t_high();
        set_mode(2'b10);
        drive(1'b0, 1'b1, 1'b0, 16'h3344);
        check("R4", 1'b0, 16'h2211);
        drive(1'b0, 1'b1, 1'b0, 16'h5566);
        check("R4", 1'b1, 16'h5533);
    endtask

    task automatic t_lane_switch();
        set_mode(2'b01);
        drive(1'b0, 1'b1, 1'b0, 16'h0077);
        check("R6", 1'b0, 16'h5533);
        mode_i = 2'b10;
        drive(1'b0, 1'b1, 1'b0, 16'h8800);
        check("R6", 1'b0, 16'h5533);
        drive(1'b0, 1'b1, 1'b0, 16'h9900);
        check("R6", 1'b1, 16'h9988);
    endtask

    task automatic t_slow();
        div_i = 16'd3;
        set_mode(2'b11);
        drive(1'b0, 1'b0, 1'b1, 16'h0101);
        check("R5", 1'b0, 16'h9988);
        drive(1'b1, 1'b1, 1'b0, 16'h0202);
        check("R8", 1'b0, 16'h9988);
        drive(1'b0, 1'b0, 1'b1, 16'h0303);
        check("R5", 1'b0, 16'h9988);
        drive(1'b0, 1'b0, 1'b1, 16'hBEEF);
        check("R5", 1'b1, 16'hBEEF);
        div_i = 16'd0;
        drive(1'b0, 1'b0, 1'b1, 16'hCAFE);
        check("R5", 1'b1, 16'hCAFE);
        drive(1'b0, 1'b0, 1'b1, 16'hF00D);
        check("R5", 1'b1, 16'hF00D);
        drive(1'b0, 1'b0, 1'b0, 16'h0000);
        check("R7", 1'b0, 16'hF00D);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_wide();
        t_low();
        t_high();
        t_lane_switch();
        t_slow();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule